// File: doc/BRIEF.md
# PLL Lock Detect Qualifier

This block turns a stream of per-cycle phase-error readings into a single lock flag for a phase-locked loop. Once per phase-detector period, a strobe arrives together with the absolute phase error, an unsigned value in nanoseconds. The block counts runs of small errors to declare lock. It counts runs of large errors to withdraw it. The two thresholds are far apart, which gives the flag hysteresis.

A mode input picks a short or a long acquisition run. A short run of three periods is the recommended setting. With a 20 µs detector period, that is 60 µs, and the long run of five periods is 100 µs. While the charge pump is tri-stated or the loop is powered down, the flag is held low and all run history is discarded.

The flag can also be routed to a shared status pin. This happens only while a 3-bit function-select field holds the value 1; otherwise the pin is driven low.

Top module: `pll_lock_qualifier`

## Requirements
- R1: With `long_mode` low and the flag low, the flag rises after the third consecutive strobe whose error is below 15. It is visible after the clock edge that takes the third strobe.
- R2: With `long_mode` high, five consecutive strobes with error below 15 are needed; after four the flag is still low.
- R3: While the flag is low, a strobe with an error of 15 or more resets the good-run count, so a full new run is needed. An error of exactly 15 is not good.
- R4: Once the flag is high, it falls only on the second consecutive strobe whose error is above 30. An error of exactly 30 is not over threshold.
- R5: While the flag is high, a strobe with an error from 15 to 30 inclusive keeps the flag high and breaks any run of over-threshold strobes.
- R6: While `cp_tristate` or `pll_pwrdn` is high, the flag is low after the next edge and strobes are ignored. After release, acquisition starts from zero.
- R7: `status_pin` equals the flag in the same cycle when `func_sel` is 1. For any other `func_sel` value it is 0.
- R8: Synchronous reset drives the flag and `status_pin` low and clears both run counts.
- R9: Clock cycles without a strobe change neither the flag nor either run count, so runs continue across gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | One-cycle strobe per phase-detector period |
| phase_err_ns | input | ERR_W | Absolute phase error in ns, unsigned |
| long_mode | input | 1 | 0: three-period run, 1: five-period run |
| cp_tristate | input | 1 | Charge pump tri-stated; forces the flag low |
| pll_pwrdn | input | 1 | Loop powered down; forces the flag low |
| func_sel | input | FSEL_W | Status pin function select; value 1 routes the flag |
| lock_flag | output | 1 | Registered lock indication |
| status_pin | output | 1 | Registered shared status pin |

## Verification
The two run counters are not visible at the ports. A wrong count therefore shows up as the flag changing one strobe too early or too late. The first strobe where this appears is the one that completes a run, so runs are checked right at their length and one short of it.

A counter that is not cleared after an overlapping in-between error, a forced clear or a reset shows up within the next three to five strobes. It appears as a premature rise or a premature drop of the flag. A wrong mux select shows on `status_pin` on the edge after `func_sel` changes.

// File: rtl/lockq_pkg.sv
package lockq_pkg;
  typedef enum logic [0:0] {
    LQ_HUNT   = 1'b0,
    LQ_LOCKED = 1'b1
  } lockq_state_e;
endpackage

// File: rtl/lockq_run_ctr.sv
module lockq_run_ctr #(
  parameter int MAX = 5,
  parameter int W   = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         hit,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CAP = W'(MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      if (!hit)            cnt <= '0;
      else if (cnt != CAP) cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAP); // R9
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(cnt)); // R9
endmodule

// File: rtl/lockq_fsm.sv
module lockq_fsm
  import lockq_pkg::*;
#(
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5,
  parameter int CLR_RUN   = 2,
  parameter int GW        = 3,
  parameter int BW        = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          meas_valid,
  input  logic          good,
  input  logic          bad,
  input  logic          forced,
  input  logic          long_mode,
  input  logic [GW-1:0] good_cnt,
  input  logic [BW-1:0] bad_cnt,
  output logic          lock_q,
  output logic          lock_d
);
  lockq_state_e state_q, state_d;
  int           need;
  logic         set_hit, clr_hit;

  always_comb begin
    need    = long_mode ? LONG_RUN : SHORT_RUN;
    set_hit = good && ((int'(good_cnt) + 1) >= need);
    clr_hit = bad  && ((int'(bad_cnt)  + 1) >= CLR_RUN);
    state_d = state_q;
    if (forced) begin
      state_d = LQ_HUNT;
    end else if (meas_valid) begin
      if (state_q == LQ_HUNT && set_hit)        state_d = LQ_LOCKED;
      else if (state_q == LQ_LOCKED && clr_hit) state_d = LQ_HUNT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LQ_HUNT;
    else     state_q <= state_d;
  end

  assign lock_q = (state_q == LQ_LOCKED);
  assign lock_d = (state_d == LQ_LOCKED);

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    forced |=> !lock_q); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!meas_valid && !forced) |=> (lock_q == $past(lock_q))); // R9
  AST_NO_SET_ON_POOR: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && meas_valid && !good) |=> !lock_q); // R3
  AST_KEEP_UNLESS_BAD: assert property (@(posedge clk) disable iff (rst)
    (lock_q && meas_valid && !bad && !forced) |=> lock_q); // R5
endmodule

// File: rtl/lockq_status_mux.sv
module lockq_status_mux #(
  parameter int FSEL_W    = 3,
  parameter int FSEL_LOCK = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FSEL_W-1:0] func_sel,
  input  logic              lock_d,
  output logic              status_pin
);
  localparam logic [FSEL_W-1:0] SEL_CODE = FSEL_W'(FSEL_LOCK);

  always_ff @(posedge clk) begin
    if (rst) status_pin <= 1'b0;
    else     status_pin <= (func_sel == SEL_CODE) ? lock_d : 1'b0;
  end

  AST_PIN_GATED: assert property (@(posedge clk) disable iff (rst)
    (func_sel != SEL_CODE) |=> !status_pin); // R7
endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier #(
  parameter int ERR_W     = 8,
  parameter int SET_NS    = 15,
  parameter int CLR_NS    = 30,
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5,
  parameter int CLR_RUN   = 2,
  parameter int FSEL_W    = 3,
  parameter int FSEL_LOCK = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid,
  input  logic [ERR_W-1:0]  phase_err_ns,
  input  logic              long_mode,
  input  logic              cp_tristate,
  input  logic              pll_pwrdn,
  input  logic [FSEL_W-1:0] func_sel,
  output logic              lock_flag,
  output logic              status_pin
);
  localparam int GMAX = (LONG_RUN > SHORT_RUN) ? LONG_RUN : SHORT_RUN;
  localparam int GW   = $clog2(GMAX + 1);
  localparam int BW   = $clog2(CLR_RUN + 1);

  logic          good, bad, forced;
  logic          lock_q, lock_d;
  logic [GW-1:0] good_cnt;
  logic [BW-1:0] bad_cnt;

  assign good   = phase_err_ns < ERR_W'(SET_NS);
  assign bad    = phase_err_ns > ERR_W'(CLR_NS);
  assign forced = cp_tristate | pll_pwrdn;

  lockq_run_ctr #(.MAX(GMAX), .W(GW)) u_good_ctr (
    .clk (clk),
    .rst (rst),
    .clr (forced),
    .step(meas_valid),
    .hit (good),
    .cnt (good_cnt)
  );

  lockq_run_ctr #(.MAX(CLR_RUN), .W(BW)) u_bad_ctr (
    .clk (clk),
    .rst (rst),
    .clr (forced | ~lock_q),
    .step(meas_valid),
    .hit (bad),
    .cnt (bad_cnt)
  );

  lockq_fsm #(
    .SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN), .CLR_RUN(CLR_RUN),
    .GW(GW), .BW(BW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .meas_valid(meas_valid),
    .good      (good),
    .bad       (bad),
    .forced    (forced),
    .long_mode (long_mode),
    .good_cnt  (good_cnt),
    .bad_cnt   (bad_cnt),
    .lock_q    (lock_q),
    .lock_d    (lock_d)
  );

  lockq_status_mux #(.FSEL_W(FSEL_W), .FSEL_LOCK(FSEL_LOCK)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .func_sel  (func_sel),
    .lock_d    (lock_d),
    .status_pin(status_pin)
  );

  assign lock_flag = lock_q;

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (!lock_flag && !status_pin)); // R8
  AST_DROP_NEEDS_BAD: assert property (@(posedge clk) disable iff (rst)
    (lock_flag && meas_valid && !bad && !forced) |=> lock_flag); // R4
endmodule

// File: tb/pll_lock_qualifier_bench.sv
module pll_lock_qualifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  // fields: valid[20] err[19:12] mode[11] tri[10] pd[9] fsel[8:6] exp_lock[5] exp_pin[4] req[3:0]
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd1}, // R1 run 1
    {1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd1}, // R1 run 2
    {1'b1, 8'd14, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd1}, // R1 run 3 sets
    {1'b1, 8'd20, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd5}, // R5 mid band
    {1'b1, 8'd40, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd4}, // R4 first bad
    {1'b1, 8'd25, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd5}, // R5 breaks bad run
    {1'b1, 8'd40, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd5}, // R5 bad run restarts
    {1'b0, 8'd99, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd9}, // R9 gap
    {1'b1, 8'd31, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd4}, // R4 second bad drops
    {1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd3}, // R3 run 1
    {1'b1, 8'd15, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd3}, // R3 exact 15 resets
    {1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd3}, // R3
    {1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd3}, // R3
    {1'b1, 8'd0,  1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd3}, // R3 full run sets
    {1'b1, 8'd30, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd4}, // R4 exact 30 not bad
    {1'b1, 8'd30, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd4}, // R4
    {1'b1, 8'd5,  1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 4'd6}, // R6 tri-state
    {1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd6}, // R6 restart 1
    {1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd6}, // R6 restart 2
    {1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd6}, // R6 restart 3
    {1'b0, 8'd5,  1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 4'd6}, // R6 power down
    {1'b1, 8'd5,  1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd2}, // R2 run 1
    {1'b1, 8'd5,  1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd2}, // R2 run 2
    {1'b1, 8'd5,  1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd2}, // R2 run 3
    {1'b1, 8'd5,  1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd2}, // R2 run 4
    {1'b1, 8'd5,  1'b1, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd2}, // R2 run 5 sets
    {1'b1, 8'd5,  1'b1, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 4'd7}, // R7 sel 2
    {1'b0, 8'd5,  1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 4'd7}, // R7 sel 0
    {1'b0, 8'd5,  1'b1, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd7}  // R7 sel 1
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       meas_valid;
  logic [7:0] phase_err_ns;
  logic       long_mode, cp_tristate, pll_pwrdn;
  logic [2:0] func_sel;
  logic       lock_flag, status_pin;
  int         checks = 0;
  int         errors = 0;
  logic       done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_lock_qualifier u_pll_lock_qualifier (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .phase_err_ns(phase_err_ns),
    .long_mode(long_mode), .cp_tristate(cp_tristate), .pll_pwrdn(pll_pwrdn),
    .func_sel(func_sel), .lock_flag(lock_flag), .status_pin(status_pin)
  );

  task automatic check(input int req, input logic exp_lock, input logic exp_pin);
    checks++;
    if (lock_flag !== exp_lock || status_pin !== exp_pin) begin
      errors++;
      $display("FAIL R%0d: lock=%b pin=%b expected lock=%b pin=%b",
               req, lock_flag, status_pin, exp_lock, exp_pin);
    end
  endtask

  task automatic apply(input logic [20:0] v);
    meas_valid   = v[20];
    phase_err_ns = v[19:12];
    long_mode    = v[11];
    cp_tristate  = v[10];
    pll_pwrdn    = v[9];
    func_sel     = v[8:6];
    @(posedge clk);
    @(negedge clk);
    check(int'(v[3:0]), v[5], v[4]);
  endtask

  initial begin
    rst = 1'b1; meas_valid = 1'b0; phase_err_ns = '0; long_mode = 1'b0;
    cp_tristate = 1'b0; pll_pwrdn = 1'b0; func_sel = 3'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(8, 1'b0, 1'b0); // R8 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) apply(VEC[i]);
    // R8: reset while locked clears flag and pin
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(8, 1'b0, 1'b0);
    rst = 1'b0;
    // R8: counts cleared, so two good strobes in short mode do not lock
    apply({1'b1, 8'd1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd8});
    apply({1'b1, 8'd1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd8});
    // R9: gaps inside an acquisition run do not break it
    apply({1'b0, 8'd90, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd9});
    apply({1'b1, 8'd1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 4'd9});
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R0: watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule